// File: doc/BRIEF.md
# SD Card SPI-Mode Reset Sequencer

This block brings a freshly powered SD card out of its native bus mode and into SPI mode without software bit-banging. A single start pulse launches a fixed sequence: a wake-up burst of serial clocks with chip select and data-out both held high, then the 48-bit reset command with chip select low. After that the block keeps clocking with data-out high and hunts, one sampled bit at a time, for the card's one-byte status reply.

The reply is found by its leading zero, because the card keeps its data line high while it has nothing to send. If no leading zero arrives within a bounded window of serial clocks, the command is sent again, up to a configurable number of times. When the sequence ends, chip select is released for a short trailing burst and the block raises `done`. At that point it also shows the captured status byte, whether the reset succeeded, and how many re-sends were needed.

The serial clock is derived from the system clock by a programmable half-period divider. It idles low and is driven in SPI mode 0: data-out changes when the serial clock falls, and the card's data line is sampled when it rises.

Top module: `sdrst_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `sclk` is 0, `cs_n` is 1, `mosi` is 1, `done` and `ok` are 0, `status` is 0xFF and `retries` is 0.
- R2: During a run, `sclk` starts low and each of its low and high phases lasts exactly HALF_DIV system clocks. The first rising edge comes HALF_DIV clocks after the start edge. Outside a run, `sclk` stays low.
- R3: Each run begins with WAKE_CYC serial clock cycles (at least 74) during which `cs_n` and `mosi` are both 1.
- R4: After the wake-up burst, `cs_n` goes low and the 48-bit frame 0x400000000095 is sent on `mosi`, most significant bit first. The frame is a start bit 0, a transmit bit 1, six index bits 0, 32 argument bits 0, the check value 1001010 and a stop bit 1. `mosi` and `cs_n` change only on the system edge where `sclk` falls, or where a run starts, and never where it rises.
- R5: After a frame, `cs_n` stays low and `mosi` stays high while the card line is sampled at each `sclk` rise. The first sampled 0 and the seven bits that follow form the status byte, first bit in bit 7. Bit 0 of the byte means idle state and bits 1 to 6 are error flags.
- R6: If RESP_WINDOW (16) consecutive samples after a frame are all 1, the frame is sent again immediately and `retries` increments. A reply whose leading 0 falls in the 16th sample is still accepted.
- R7: If the window expires while `retries` equals MAX_RETRY, the run ends with `ok` = 0 and `status` = 0xFF, and `retries` stays at MAX_RETRY.
- R8: After the status byte, or after the final timeout, `cs_n` returns high for 8 serial cycles with `mosi` high. On the edge that ends the eighth cycle, `done` rises, with `sclk` 0, `cs_n` 1 and `mosi` 1.
- R9: `ok` is 1 only when `done` is 1 and the captured status byte equals 0x01. Any other byte gives `ok` = 0 and is still shown on `status`.
- R10: `start` has no effect while a run is in progress. A `start` pulse while `done` is high clears `done` on the next edge and begins a new run.
- R11: Raising the synchronous reset in the middle of a run returns all outputs to the state of R1 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a run |
| miso | input | 1 | Serial data from the card |
| sclk | output | 1 | Serial clock to the card, idles low |
| cs_n | output | 1 | Active-low chip select, idles high |
| mosi | output | 1 | Serial data to the card, idles high |
| done | output | 1 | Run finished; held until the next start or reset |
| ok | output | 1 | Run finished with status byte 0x01 |
| status | output | 8 | Captured status byte, 0xFF when no reply was found |
| retries | output | $clog2(MAX_RETRY+1) | Number of re-sent frames in the current or last run |

## Verification
Every result here lands on a known edge. The first `sclk` rise comes HALF_DIV clocks after the start edge. Each data-out bit appears on the edge where `sclk` falls, and each card bit is taken on the edge where `sclk` rises. `retries` steps on the falling edge that ends the sixteenth idle sample, and `done`, `ok` and `status` update together on the falling edge that ends the eighth trailing cycle.

The bench steps a procedural reference through the same phases, HALF_DIV edges at a time. It reads the card line on the rising-phase edge and compares all outputs on each falling system-clock edge, so every expectation is sampled half a cycle after the edge that produced it. A behavioural card answers after a chosen number of serial clocks, which places the reply at the first, the last and one past the last sample of the window.

// File: rtl/sdrst_pkg.sv
package sdrst_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAKE,
      ST_CMD,
      ST_WAIT,
      ST_RECV,
      ST_TAIL,
      ST_DONE
   } sdrst_state_t;

   localparam int SDRST_FRAME_W = 48;
   localparam int SDRST_TAIL_CYC = 8;
   localparam int SDRST_BYTE_W = 8;

   // start 0, transmit 1, index 0, argument 0, check 1001010, stop 1
   localparam logic [SDRST_FRAME_W-1:0] SDRST_RESET_FRAME =
      {2'b01, 6'd0, 32'd0, 7'b1001010, 1'b1};

   localparam logic [SDRST_BYTE_W-1:0] SDRST_GOOD_STATUS = 8'h01;
   localparam logic [SDRST_BYTE_W-1:0] SDRST_NO_STATUS = 8'hFF;

endpackage

// File: rtl/sdrst_tick.sv
module sdrst_tick #(
   parameter int HALF_DIV = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int DW = $clog2(HALF_DIV);
         localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);
         logic [DW-1:0] div_q;

         assign tick = run && (div_q == LAST);

         always_ff @(posedge clk) begin
            if (rst || !run || tick) div_q <= '0;
            else                     div_q <= div_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/sdrst_sclk.sv
module sdrst_sclk (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic tick,
   output logic sclk,
   output logic rise,
   output logic fall
);

   assign rise = tick && !sclk;
   assign fall = tick && sclk;

   always_ff @(posedge clk) begin
      if (rst || !run) sclk <= 1'b0;
      else if (tick)   sclk <= ~sclk;
   end

endmodule

// File: rtl/sdrst_ctrl.sv
module sdrst_ctrl
   import sdrst_pkg::*;
#(
   parameter int WAKE_CYC = 80,
   parameter int RESP_WINDOW = 16,
   parameter int MAX_RETRY = 8
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           start,
   input  logic                           miso,
   input  logic                           rise,
   input  logic                           fall,
   output logic                           run,
   output logic                           cs_n,
   output logic                           mosi,
   output logic                           done,
   output logic                           ok,
   output logic [SDRST_BYTE_W-1:0]        status,
   output logic [$clog2(MAX_RETRY+1)-1:0] retries
);

   localparam int RW = $clog2(MAX_RETRY + 1);
   localparam int MAX_A = (WAKE_CYC > SDRST_FRAME_W) ? WAKE_CYC : SDRST_FRAME_W;
   localparam int MAXC = (MAX_A > RESP_WINDOW) ? MAX_A : RESP_WINDOW;
   localparam int CW = $clog2(MAXC + 1);
   localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);
   localparam logic [CW-1:0] FRAME_LAST = CW'(SDRST_FRAME_W - 1);
   localparam logic [CW-1:0] WIN_END = CW'(RESP_WINDOW);
   localparam logic [CW-1:0] BYTE_END = CW'(SDRST_BYTE_W);
   localparam logic [CW-1:0] TAIL_LAST = CW'(SDRST_TAIL_CYC - 1);
   localparam logic [RW-1:0] RETRY_MAX = RW'(MAX_RETRY);

   sdrst_state_t              state;
   logic [CW-1:0]             cnt;
   logic [SDRST_FRAME_W-1:0]  frame_sr;
   logic [SDRST_BYTE_W-1:0]   rx_sr;
   logic                      got;

   assign run = (state != ST_IDLE) && (state != ST_DONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         frame_sr <= '0;
         rx_sr    <= '0;
         got      <= 1'b0;
         cs_n     <= 1'b1;
         mosi     <= 1'b1;
         done     <= 1'b0;
         ok       <= 1'b0;
         status   <= SDRST_NO_STATUS;
         retries  <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state   <= ST_WAKE;
                  cnt     <= '0;
                  got     <= 1'b0;
                  cs_n    <= 1'b1;
                  mosi    <= 1'b1;
                  done    <= 1'b0;
                  ok      <= 1'b0;
                  status  <= SDRST_NO_STATUS;
                  retries <= '0;
               end
            end
            ST_WAKE: begin
               if (fall) begin
                  if (cnt == WAKE_LAST) begin
                     state    <= ST_CMD;
                     cnt      <= '0;
                     cs_n     <= 1'b0;
                     mosi     <= SDRST_RESET_FRAME[SDRST_FRAME_W-1];
                     frame_sr <= {SDRST_RESET_FRAME[SDRST_FRAME_W-2:0], 1'b1};
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_CMD: begin
               if (fall) begin
                  if (cnt == FRAME_LAST) begin
                     state <= ST_WAIT;
                     cnt   <= '0;
                     mosi  <= 1'b1;
                  end else begin
                     cnt      <= cnt + 1'b1;
                     mosi     <= frame_sr[SDRST_FRAME_W-1];
                     frame_sr <= {frame_sr[SDRST_FRAME_W-2:0], 1'b1};
                  end
               end
            end
            ST_WAIT: begin
               if (rise) begin
                  if (!miso) begin
                     state <= ST_RECV;
                     rx_sr <= {rx_sr[SDRST_BYTE_W-2:0], miso};
                     cnt   <= CW'(1);
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else if (fall && cnt == WIN_END) begin
                  cnt <= '0;
                  if (retries == RETRY_MAX) begin
                     state <= ST_TAIL;
                     cs_n  <= 1'b1;
                  end else begin
                     state    <= ST_CMD;
                     retries  <= retries + 1'b1;
                     mosi     <= SDRST_RESET_FRAME[SDRST_FRAME_W-1];
                     frame_sr <= {SDRST_RESET_FRAME[SDRST_FRAME_W-2:0], 1'b1};
                  end
               end
            end
            ST_RECV: begin
               if (rise) begin
                  rx_sr <= {rx_sr[SDRST_BYTE_W-2:0], miso};
                  cnt   <= cnt + 1'b1;
               end else if (fall && cnt == BYTE_END) begin
                  state <= ST_TAIL;
                  cnt   <= '0;
                  cs_n  <= 1'b1;
                  got   <= 1'b1;
               end
            end
            ST_TAIL: begin
               if (fall) begin
                  if (cnt == TAIL_LAST) begin
                     state  <= ST_DONE;
                     done   <= 1'b1;
                     status <= got ? rx_sr : SDRST_NO_STATUS;
                     ok     <= got && (rx_sr == SDRST_GOOD_STATUS);
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sdrst_seq.sv
module sdrst_seq #(
   parameter int HALF_DIV = 64,
   parameter int WAKE_CYC = 80,
   parameter int RESP_WINDOW = 16,
   parameter int MAX_RETRY = 8
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           start,
   input  logic                           miso,
   output logic                           sclk,
   output logic                           cs_n,
   output logic                           mosi,
   output logic                           done,
   output logic                           ok,
   output logic [7:0]                     status,
   output logic [$clog2(MAX_RETRY+1)-1:0] retries
);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("sdrst_seq: HALF_DIV must be at least 1");
      end
      if (WAKE_CYC < 74) begin : g_bad_wake
         $error("sdrst_seq: WAKE_CYC must be at least 74");
      end
      if (RESP_WINDOW < 1) begin : g_bad_window
         $error("sdrst_seq: RESP_WINDOW must be at least 1");
      end
      if (MAX_RETRY < 1) begin : g_bad_retry
         $error("sdrst_seq: MAX_RETRY must be at least 1");
      end
   endgenerate

   logic run;
   logic tick;
   logic rise;
   logic fall;

   sdrst_tick #(
      .HALF_DIV(HALF_DIV)
   ) u_tick (
      .clk (clk),
      .rst (rst),
      .run (run),
      .tick(tick)
   );

   sdrst_sclk u_sclk (
      .clk (clk),
      .rst (rst),
      .run (run),
      .tick(tick),
      .sclk(sclk),
      .rise(rise),
      .fall(fall)
   );

   sdrst_ctrl #(
      .WAKE_CYC   (WAKE_CYC),
      .RESP_WINDOW(RESP_WINDOW),
      .MAX_RETRY  (MAX_RETRY)
   ) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .miso   (miso),
      .rise   (rise),
      .fall   (fall),
      .run    (run),
      .cs_n   (cs_n),
      .mosi   (mosi),
      .done   (done),
      .ok     (ok),
      .status (status),
      .retries(retries)
   );

endmodule

// File: rtl/sdrst_seq_chk.sv
module sdrst_seq_chk #(
   parameter int HALF_DIV = 64,
   parameter int MAX_RETRY = 8
) (
   input logic                           clk,
   input logic                           rst,
   input logic                           start,
   input logic                           sclk,
   input logic                           cs_n,
   input logic                           mosi,
   input logic                           done,
   input logic                           ok,
   input logic [7:0]                     status,
   input logic [$clog2(MAX_RETRY+1)-1:0] retries
);

   int unsigned hi_cnt;

   always_ff @(posedge clk) begin
      if (rst)       hi_cnt <= 0;
      else if (sclk) hi_cnt <= hi_cnt + 1;
      else           hi_cnt <= 0;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!sclk && cs_n && mosi && !done && !ok && retries == '0)); // R1

   AST_SCLK_HIGH_PHASE: assert property (@(posedge clk) disable iff (rst)
      $fell(sclk) |-> (hi_cnt == HALF_DIV)); // R2

   AST_LINES_HELD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(sclk) |-> ($stable(mosi) && $stable(cs_n))); // R4

   AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
      retries <= ($clog2(MAX_RETRY+1))'(MAX_RETRY)); // R7

   AST_DONE_LINES_IDLE: assert property (@(posedge clk) disable iff (rst)
      done |-> (!sclk && cs_n && mosi)); // R8

   AST_OK_NEEDS_GOOD_BYTE: assert property (@(posedge clk) disable iff (rst)
      ok |-> (done && status == 8'h01)); // R9

   AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
      (done && start) |=> !done); // R10

endmodule

bind sdrst_seq sdrst_seq_chk #(
   .HALF_DIV (HALF_DIV),
   .MAX_RETRY(MAX_RETRY)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .start  (start),
   .sclk   (sclk),
   .cs_n   (cs_n),
   .mosi   (mosi),
   .done   (done),
   .ok     (ok),
   .status (status),
   .retries(retries)
);

// File: tb/sdrst_seq_bench.sv
module sdrst_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HD = 2;
   localparam int WAKE = 80;
   localparam int WIN = 16;
   localparam int MAXR = 3;
   localparam int RW = $clog2(MAXR + 1);
   localparam logic [47:0] FRAME = 48'h4000_0000_0095;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic miso = 1'b1;
   logic sclk, cs_n, mosi, done, ok;
   logic [7:0] status;
   logic [RW-1:0] retries;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sdrst_seq #(
      .HALF_DIV   (HD),
      .WAKE_CYC   (WAKE),
      .RESP_WINDOW(WIN),
      .MAX_RETRY  (MAXR)
   ) u_sdrst_seq (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .miso   (miso),
      .sclk   (sclk),
      .cs_n   (cs_n),
      .mosi   (mosi),
      .done   (done),
      .ok     (ok),
      .status (status),
      .retries(retries)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   logic e_sclk = 1'b0, e_cs = 1'b1, e_mosi = 1'b1, e_done = 1'b0, e_ok = 1'b0;
   logic [7:0] e_status = 8'hFF;
   int e_ret = 0;
   bit m_abort = 1'b0;

   task automatic m_idle();
      e_sclk = 1'b0; e_cs = 1'b1; e_mosi = 1'b1;
      e_done = 1'b0; e_ok = 1'b0; e_status = 8'hFF; e_ret = 0;
   endtask

   task automatic m_edge();
      @(posedge clk);
      if (rst) m_abort = 1'b1;
   endtask

   task automatic m_cycle(input logic c, input logic m, output logic s);
      s = 1'b1;
      e_cs = c; e_mosi = m; e_sclk = 1'b0;
      repeat (HD) begin m_edge(); if (m_abort) return; end
      e_sclk = 1'b1;
      s = miso;
      repeat (HD) begin m_edge(); if (m_abort) return; end
      e_sclk = 1'b0;
   endtask

   task automatic m_run();
      logic s;
      logic [7:0] b;
      bit got;
      got = 1'b0;
      b = 8'hFF;
      repeat (WAKE) begin m_cycle(1'b1, 1'b1, s); if (m_abort) return; end
      forever begin
         for (int i = 47; i >= 0; i--) begin
            m_cycle(1'b0, FRAME[i], s);
            if (m_abort) return;
         end
         for (int w = 0; w < WIN && !got; w++) begin
            m_cycle(1'b0, 1'b1, s);
            if (m_abort) return;
            if (s == 1'b0) got = 1'b1;
         end
         if (got) begin
            b = 8'h00;
            for (int j = 0; j < 7; j++) begin
               m_cycle(1'b0, 1'b1, s);
               if (m_abort) return;
               b = {b[6:0], s};
            end
            break;
         end
         if (e_ret == MAXR) break;
         e_ret++;
      end
      repeat (8) begin m_cycle(1'b1, 1'b1, s); if (m_abort) return; end
      e_done = 1'b1;
      e_ok = got && (b == 8'h01);
      e_status = got ? b : 8'hFF;
   endtask

   initial begin
      forever begin
         m_edge();
         if (rst) begin
            m_idle();
            m_abort = 1'b0;
         end else if (start) begin
            m_abort = 1'b0;
            e_done = 1'b0; e_ok = 1'b0; e_status = 8'hFF; e_ret = 0;
            m_run();
            if (m_abort) begin
               m_idle();
               m_abort = 1'b0;
            end
         end
      end
   end

   // ---------------- behavioural card ----------------
   int c_delay = 0, c_ignore = 0, c_cmds = 0;
   logic [7:0] c_byte = 8'h01;
   logic [47:0] c_frame = '0, c_last = '0;
   int c_cnt = 0, c_fcnt = 0, c_idx = 0;
   bit c_resp = 1'b0;
   logic c_prev = 1'b0;

   always @(negedge clk) begin
      if (cs_n) begin
         c_cnt = 0; c_resp = 1'b0; miso = 1'b1;
      end else if (sclk && !c_prev) begin
         if (c_cnt == 0 && mosi == 1'b0) begin
            c_cnt = 1; c_frame = {47'd0, mosi};
         end else if (c_cnt > 0) begin
            c_frame = {c_frame[46:0], mosi};
            c_cnt++;
            if (c_cnt == 48) begin
               c_cnt = 0;
               c_cmds++;
               c_last = c_frame;
               c_resp = (c_cmds > c_ignore);
               c_fcnt = 0;
               c_idx = 0;
            end
         end
      end else if (!sclk && c_prev && c_resp) begin
         if (c_fcnt >= c_delay && c_idx < 8) begin
            miso = c_byte[7 - c_idx];
            c_idx++;
         end else begin
            miso = 1'b1;
         end
         c_fcnt++;
      end
      c_prev = sclk;
   end

   // ---------------- per-clock comparison ----------------
   bit cmp_en = 1'b0;

   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R2 sclk", sclk, e_sclk);
         chk("R4 cs_n", cs_n, e_cs);
         chk("R3 mosi", mosi, e_mosi);
         chk("R8 done", done, e_done);
         chk("R9 ok", ok, e_ok);
         chk("R5 status", status, e_status);
         chk("R6 retries", retries, e_ret);
      end
   end

   task automatic run_case(input int dly, input int ign, input logic [7:0] byt,
                           input bit busy_pulse);
      int k;
      c_delay = dly; c_ignore = ign; c_byte = byt; c_cmds = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R10 done cleared by start", done, 0);
      if (busy_pulse) begin
         repeat (50) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
         repeat (4) @(negedge clk);
         chk("R10 busy start ignored, still in wake", cs_n, 1);
      end
      k = 0;
      while (!done && k < 20000) begin
         @(negedge clk);
         k++;
      end
      chk("R8 done reached", done, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      cmp_en = 1'b1;
      chk("R1 sclk idle", sclk, 0);
      chk("R1 cs_n idle", cs_n, 1);
      chk("R1 mosi idle", mosi, 1);
      chk("R1 done idle", done, 0);
      chk("R1 status idle", status, 8'hFF);
      rst = 1'b0;

      // nominal reply, busy start ignored
      run_case(3, 0, 8'h01, 1'b1);
      chk("R9 ok on 0x01", ok, 1);
      chk("R5 status byte", status, 8'h01);
      chk("R6 no retries", retries, 0);
      chk("R4 frame seen by card", int'(c_last == FRAME), 1);
      chk("R4 one frame sent", c_cmds, 1);

      // restart from done, reply on the last window sample
      run_case(15, 0, 8'h01, 1'b0);
      chk("R5 reply at window edge ok", ok, 1);
      chk("R6 no retries at window edge", retries, 0);

      // two frames ignored
      run_case(2, 2, 8'h01, 1'b0);
      chk("R6 retries after two timeouts", retries, 2);
      chk("R6 frames sent", c_cmds, 3);
      chk("R9 ok after retries", ok, 1);

      // error status byte
      run_case(0, 0, 8'h05, 1'b0);
      chk("R9 ok low on bad byte", ok, 0);
      chk("R5 bad byte shown", status, 8'h05);

      // card silent
      run_case(0, 99, 8'h01, 1'b0);
      chk("R7 retries at limit", retries, MAXR);
      chk("R7 ok low on silence", ok, 0);
      chk("R7 status none", status, 8'hFF);
      chk("R7 frames sent", c_cmds, MAXR + 1);

      // reply one sample past the window
      run_case(16, 0, 8'h01, 1'b0);
      chk("R6 late reply times out", retries, MAXR);
      chk("R6 late reply not ok", ok, 0);

      // reset in the middle of the command
      c_delay = 0; c_ignore = 0; c_byte = 8'h01;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (WAKE * 2 * HD + 40) @(negedge clk);
      chk("R11 command under way", cs_n, 0);
      rst = 1'b1;
      @(negedge clk);
      chk("R11 cs_n idle after reset", cs_n, 1);
      chk("R11 sclk idle after reset", sclk, 0);
      chk("R11 mosi idle after reset", mosi, 1);
      chk("R11 done low after reset", done, 0);
      rst = 1'b0;
      run_case(1, 0, 8'h01, 1'b0);
      chk("R11 run after reset ok", ok, 1);

      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule